// File: doc/BRIEF.md
# Shared Memory Port Arbiter

This block lets several clients share one synchronous memory port. Each client presents a request with a direction bit, an address, write data and two half enables that mark which 32-bit halves of the 64-bit word matter. In the same cycle the arbiter picks one winner, raises that client's acknowledge and drives the winner's command onto the memory port. A request counts as accepted in the cycle its acknowledge is high.

The memory returns read data a fixed number of cycles after it accepts a command. A small tag pipeline carries the winner's identity, its direction and its half enables alongside that latency. When a read's data arrives, the pipeline raises data-valid, and the per-half valids, for the client that issued the read. Writes never raise a data-valid.

A policy input selects either fixed priority, where the lowest client index always wins, or round-robin rotation. The policy is captured only in cycles with no pending request, so a switch never happens in the middle of contention.

Top module: `mem_arbiter`

## Requirements
- R1: In every cycle at most one bit of `cl_ack` is high, it is high only for a client whose `cl_req` is high, and whenever any request is present exactly one acknowledge is given in that same cycle.
- R2: With the captured policy equal to 0 (fixed priority), the requesting client with the lowest index is acknowledged, so a higher index can be starved indefinitely.
- R3: With the captured policy equal to 1 (round-robin), the search starts at a pointer and runs upward with wrap-around. After each grant, in either policy, the pointer becomes the grantee index plus one, modulo the client count. The pointer holds when nothing is granted and is 0 after reset. Under full load each of N clients receives exactly one grant in every N cycles.
- R4: `policy_sel` is captured only at a clock edge that closes a cycle with no request high, and it takes effect in the next cycle. The captured policy is 0 after reset.
- R5: In a cycle with a grant, `mem_en` is 1 and `mem_we`, `mem_addr`, `mem_wdata` and `mem_be` are the grantee's direction, address, data and `{hi_en, lo_en}` (bit 0 = low half, bits 31:0). Without a grant, `mem_en` is 0.
- R6: For a read acknowledged in cycle t, `cl_dv` of that client alone is high in cycle t+LATENCY, and `cl_rdata` equals `mem_rdata` in that cycle.
- R7: A write produces no data-valid, for any client, LATENCY cycles later.
- R8: `cl_dv_lo` and `cl_dv_hi` for a client are its `cl_dv` qualified by the low and high enables it presented in the acknowledge cycle.
- R9: While `rst_n` is low no acknowledge is given and `mem_en` stays 0. The tag pipeline is cleared, so no data-valid appears for reads accepted before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy_sel | input | 1 | 0 fixed priority, 1 round-robin |
| cl_req | input | N_CLIENTS | Per-client request |
| cl_wr | input | N_CLIENTS | Per-client direction, 1 = write |
| cl_lo_en | input | N_CLIENTS | Per-client low-half enable |
| cl_hi_en | input | N_CLIENTS | Per-client high-half enable |
| cl_addr | input | N_CLIENTS*ADDR_W | Client addresses, client i at slice i |
| cl_wdata | input | N_CLIENTS*DATA_W | Client write data, client i at slice i |
| cl_ack | output | N_CLIENTS | One-hot acknowledge |
| cl_rdata | output | DATA_W | Read data shared by all clients |
| cl_dv | output | N_CLIENTS | Read data-valid per client |
| cl_dv_lo | output | N_CLIENTS | Low-half data-valid per client |
| cl_dv_hi | output | N_CLIENTS | High-half data-valid per client |
| mem_en | output | 1 | Memory command strobe |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 2 | Half enables {high, low} |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, LATENCY cycles after command |

## Verification
A wrong rotation pointer or captured policy shows up at `cl_ack` in the very next contended cycle, because the bench's reference model predicts the winner every cycle. A corrupted tag in the latency pipeline appears exactly LATENCY cycles after the faulty acknowledge: the valid lands on the wrong client, a half valid is wrong, or a write produces a valid. A reset that fails to clear the pipeline shows as a stray valid within LATENCY cycles of reset release.

// File: rtl/mem_arb_pkg.sv
package mem_arb_pkg;
    // Arbitration policy encoding shared by the top and its checker
    typedef enum logic {
        POL_FIXED  = 1'b0,
        POL_ROTATE = 1'b1
    } policy_e;
endpackage

// File: rtl/arb_select.sv
// arb_select: combinational winner search over N requesters.
// Fixed policy searches upward from index 0; rotating policy searches
// upward from start_ptr with wrap-around.
// Assumes N >= 2 and start_ptr < N.
module arb_select #(
    parameter int N   = 4,
    parameter int IDW = $clog2(N)
) (
    input  logic           rotate,
    input  logic [IDW-1:0] start_ptr,
    input  logic [N-1:0]   req,
    output logic [N-1:0]   grant,
    output logic [IDW-1:0] gid,
    output logic           any
);
    // Scan from the chosen start index and keep the first requester found
    always_comb begin
        int base;
        int idx;
        grant = '0;
        gid   = '0;
        any   = 1'b0;
        base  = rotate ? int'(start_ptr) : 0;
        for (int k = 0; k < N; k++) begin
            idx = base + k;
            if (idx >= N) idx = idx - N;
            if (!any && req[idx]) begin
                grant[idx] = 1'b1;
                gid        = IDW'(idx);
                any        = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tag_pipe.sv
// tag_pipe: shift register that delays a read tag (client id and half
// enables) by DEPTH cycles, matching the memory latency.
// Assumes DEPTH >= 1; synchronous reset clears every stage.
module tag_pipe #(
    parameter int DEPTH = 4,
    parameter int IDW   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_live,
    input  logic [IDW-1:0] in_id,
    input  logic           in_lo,
    input  logic           in_hi,
    output logic           out_live,
    output logic [IDW-1:0] out_id,
    output logic           out_lo,
    output logic           out_hi
);
    logic [DEPTH-1:0] live_q;
    logic [DEPTH-1:0] lo_q;
    logic [DEPTH-1:0] hi_q;
    logic [IDW-1:0]   id_q [DEPTH];

    // Stage 0 captures the new tag each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q[0] <= 1'b0;
            lo_q[0]   <= 1'b0;
            hi_q[0]   <= 1'b0;
            id_q[0]   <= '0;
        end else begin
            live_q[0] <= in_live;
            lo_q[0]   <= in_lo;
            hi_q[0]   <= in_hi;
            id_q[0]   <= in_id;
        end
    end

    genvar s;
    generate
        for (s = 1; s < DEPTH; s++) begin : g_stage
            // Each later stage copies the one before it
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    live_q[s] <= 1'b0;
                    lo_q[s]   <= 1'b0;
                    hi_q[s]   <= 1'b0;
                    id_q[s]   <= '0;
                end else begin
                    live_q[s] <= live_q[s-1];
                    lo_q[s]   <= lo_q[s-1];
                    hi_q[s]   <= hi_q[s-1];
                    id_q[s]   <= id_q[s-1];
                end
            end
        end
    endgenerate

    assign out_live = live_q[DEPTH-1];
    assign out_lo   = lo_q[DEPTH-1];
    assign out_hi   = hi_q[DEPTH-1];
    assign out_id   = id_q[DEPTH-1];
endmodule

// File: rtl/mem_arbiter.sv
// mem_arbiter: lets N_CLIENTS share one fixed-latency memory port.
// Grants are combinational in the request cycle; read valids return
// LATENCY cycles later through tag_pipe. The policy input is captured
// only in idle cycles. Assumes the memory returns read data exactly
// LATENCY cycles after a command and N_CLIENTS >= 2.
module mem_arbiter #(
    parameter int N_CLIENTS = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 64,
    parameter int LATENCY   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          policy_sel,
    input  logic [N_CLIENTS-1:0]          cl_req,
    input  logic [N_CLIENTS-1:0]          cl_wr,
    input  logic [N_CLIENTS-1:0]          cl_lo_en,
    input  logic [N_CLIENTS-1:0]          cl_hi_en,
    input  logic [N_CLIENTS*ADDR_W-1:0]   cl_addr,
    input  logic [N_CLIENTS*DATA_W-1:0]   cl_wdata,
    output logic [N_CLIENTS-1:0]          cl_ack,
    output logic [DATA_W-1:0]             cl_rdata,
    output logic [N_CLIENTS-1:0]          cl_dv,
    output logic [N_CLIENTS-1:0]          cl_dv_lo,
    output logic [N_CLIENTS-1:0]          cl_dv_hi,
    output logic                          mem_en,
    output logic                          mem_we,
    output logic [1:0]                    mem_be,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [DATA_W-1:0]             mem_wdata,
    input  logic [DATA_W-1:0]             mem_rdata
);
    import mem_arb_pkg::*;

    localparam int IDW = $clog2(N_CLIENTS);
    localparam logic [IDW-1:0] LAST_ID = IDW'(N_CLIENTS - 1);

    policy_e          mode_q;
    logic [IDW-1:0]   ptr_q;
    logic [N_CLIENTS-1:0] grant;
    logic [IDW-1:0]   gid;
    logic             found;
    logic             take;
    logic             p_live;
    logic [IDW-1:0]   p_id;
    logic             p_lo;
    logic             p_hi;

    // Policy register: updates only when no client is requesting
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= POL_FIXED;
        else if (~|cl_req)  mode_q <= policy_e'(policy_sel);
    end

    arb_select #(.N(N_CLIENTS), .IDW(IDW)) i_sel (
        .rotate    (mode_q == POL_ROTATE),
        .start_ptr (ptr_q),
        .req       (cl_req),
        .grant     (grant),
        .gid       (gid),
        .any       (found)
    );

    assign take = found && rst_n;

    // Rotation pointer: moves past the latest grantee, holds when idle
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr_q <= '0;
        else if (take)  ptr_q <= (gid == LAST_ID) ? '0 : gid + 1'b1;
    end

    // Route the winning command to the memory port
    always_comb begin
        cl_ack    = take ? grant : '0;
        mem_en    = take;
        mem_we    = cl_wr[gid];
        mem_be    = {cl_hi_en[gid], cl_lo_en[gid]};
        mem_addr  = cl_addr[int'(gid)*ADDR_W +: ADDR_W];
        mem_wdata = cl_wdata[int'(gid)*DATA_W +: DATA_W];
    end

    tag_pipe #(.DEPTH(LATENCY), .IDW(IDW)) i_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_live  (take && !cl_wr[gid]),
        .in_id    (gid),
        .in_lo    (cl_lo_en[gid]),
        .in_hi    (cl_hi_en[gid]),
        .out_live (p_live),
        .out_id   (p_id),
        .out_lo   (p_lo),
        .out_hi   (p_hi)
    );

    assign cl_rdata = mem_rdata;

    genvar c;
    generate
        for (c = 0; c < N_CLIENTS; c++) begin : g_dv
            // Decode the returning tag into this client's valids
            always_comb begin
                cl_dv[c]    = p_live && (p_id == IDW'(c));
                cl_dv_lo[c] = cl_dv[c] && p_lo;
                cl_dv_hi[c] = cl_dv[c] && p_hi;
            end
        end
    endgenerate
endmodule

// File: rtl/mem_arbiter_chk.sv
// mem_arbiter_chk: property checks on the arbiter ports and the captured
// policy, attached to every mem_arbiter instance by bind.
module mem_arbiter_chk #(
    parameter int N_CLIENTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_CLIENTS-1:0] cl_req,
    input logic [N_CLIENTS-1:0] cl_ack,
    input logic [N_CLIENTS-1:0] cl_dv,
    input logic [N_CLIENTS-1:0] cl_dv_lo,
    input logic [N_CLIENTS-1:0] cl_dv_hi,
    input logic                 mem_en,
    input logic                 mode_q
);
    a_r1_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cl_ack));
    a_r1_ack_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_ack & ~cl_req) == '0);
    a_r1_no_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (|cl_req) |-> (|cl_ack));
    a_r5_strobe_matches: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en == (|cl_ack));
    a_r6_one_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cl_dv));
    a_r8_halves_inside: assert property (@(posedge clk) disable iff (!rst_n)
        ((cl_dv_lo | cl_dv_hi) & ~cl_dv) == '0);
    a_r4_policy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (|cl_req) |=> $stable(mode_q));
endmodule

bind mem_arbiter mem_arbiter_chk #(.N_CLIENTS(N_CLIENTS)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cl_req   (cl_req),
    .cl_ack   (cl_ack),
    .cl_dv    (cl_dv),
    .cl_dv_lo (cl_dv_lo),
    .cl_dv_hi (cl_dv_hi),
    .mem_en   (mem_en),
    .mode_q   (mode_q)
);

// File: tb/test_mem_arbiter.sv
module test_mem_arbiter;
    localparam int N   = 4;
    localparam int AW  = 8;
    localparam int DW  = 64;
    localparam int LAT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic policy_sel = 1'b0;
    logic [N-1:0] req = '0, wr = '0, lo = '0, hi = '0;
    logic [N*AW-1:0] addr = '0;
    logic [N*DW-1:0] wdata = '0;
    logic [N-1:0] ack, dv, dv_lo, dv_hi;
    logic [DW-1:0] rdata, mem_wdata;
    logic mem_en, mem_we;
    logic [1:0] mem_be;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;

    always #4 clk = ~clk;

    mem_arbiter #(.N_CLIENTS(N), .ADDR_W(AW), .DATA_W(DW), .LATENCY(LAT)) i_mem_arbiter (
        .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel),
        .cl_req(req), .cl_wr(wr), .cl_lo_en(lo), .cl_hi_en(hi),
        .cl_addr(addr), .cl_wdata(wdata), .cl_ack(ack), .cl_rdata(rdata),
        .cl_dv(dv), .cl_dv_lo(dv_lo), .cl_dv_hi(dv_hi),
        .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    // reference model state
    int m_mode = 0, m_ptr = 0;
    int p_id[LAT];
    bit p_lo[LAT], p_hi[LAT];
    logic [DW-1:0] md[LAT];
    logic [DW-1:0] marr[256];
    int gcount[N];
    logic [N-1:0] seen_ack;

    task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock cycle: compare outputs against the model, then advance it
    task automatic tick();
        int g;
        logic [N-1:0] eack;
        logic [N-1:0] edv, elo, ehi;
        #1;
        g = -1;
        if (rst_n) begin
            for (int k = 0; k < N; k++) begin
                int idx;
                idx = ((m_mode == 1) ? m_ptr : 0) + k;
                if (idx >= N) idx -= N;
                if (g < 0 && req[idx]) g = idx;
            end
        end
        eack = (g >= 0) ? (N'(1) << g) : '0;
        seen_ack = ack;
        chk(ack == eack, "R1/R2/R3/R9 ack", DW'(ack), DW'(eack));
        chk(mem_en == (g >= 0), "R5/R9 mem_en", DW'(mem_en), DW'(g >= 0));
        if (g >= 0) begin
            chk(mem_we == wr[g], "R5 mem_we", DW'(mem_we), DW'(wr[g]));
            chk(mem_be == {hi[g], lo[g]}, "R5 mem_be", DW'(mem_be), DW'({hi[g], lo[g]}));
            chk(mem_addr == addr[g*AW +: AW], "R5 mem_addr", DW'(mem_addr), DW'(addr[g*AW +: AW]));
            chk(mem_wdata == wdata[g*DW +: DW], "R5 mem_wdata", mem_wdata, wdata[g*DW +: DW]);
            gcount[g]++;
        end
        edv = '0; elo = '0; ehi = '0;
        if (p_id[LAT-1] >= 0) begin
            edv[p_id[LAT-1]] = 1'b1;
            elo[p_id[LAT-1]] = p_lo[LAT-1];
            ehi[p_id[LAT-1]] = p_hi[LAT-1];
            chk(rdata == md[LAT-1], "R6 rdata", rdata, md[LAT-1]);
        end
        chk(dv == edv, "R6/R7/R9 dv", DW'(dv), DW'(edv));
        chk({dv_hi, dv_lo} == {ehi, elo}, "R8 half valids", DW'({dv_hi, dv_lo}), DW'({ehi, elo}));
        @(posedge clk);
        for (int s = LAT - 1; s > 0; s--) begin
            p_id[s] = p_id[s-1]; p_lo[s] = p_lo[s-1]; p_hi[s] = p_hi[s-1]; md[s] = md[s-1];
        end
        p_id[0] = -1; p_lo[0] = 0; p_hi[0] = 0; md[0] = '0;
        if (!rst_n) begin
            m_mode = 0; m_ptr = 0;
            for (int s = 0; s < LAT; s++) p_id[s] = -1;
        end else begin
            if (req == '0) m_mode = int'(policy_sel);
            if (g >= 0) begin
                int a;
                a = int'(addr[g*AW +: AW]);
                m_ptr = (g + 1) % N;
                if (wr[g]) begin
                    if (lo[g]) marr[a][31:0]  = wdata[g*DW +: 32];
                    if (hi[g]) marr[a][63:32] = wdata[g*DW + 32 +: 32];
                end else begin
                    p_id[0] = g; p_lo[0] = lo[g]; p_hi[0] = hi[g]; md[0] = marr[a];
                end
            end
        end
        mem_rdata <= md[LAT-1];
        @(negedge clk);
    endtask

    task automatic rand_inputs(int dens);
        for (int c = 0; c < N; c++) begin
            req[c] = ($urandom % 100) < dens;
            wr[c]  = $urandom % 2;
            lo[c]  = $urandom % 2;
            hi[c]  = $urandom % 2;
            addr[c*AW +: AW] = AW'($urandom % 16);
            wdata[c*DW +: DW] = {$urandom, $urandom};
        end
    endtask

    task automatic clear_counts();
        for (int c = 0; c < N; c++) gcount[c] = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int s = 0; s < LAT; s++) begin p_id[s] = -1; md[s] = '0; end
        for (int a = 0; a < 256; a++) marr[a] = {32'(a), 32'(~a)};
        @(negedge clk);
        // R9: requests during reset are ignored
        for (int i = 0; i < 3; i++) begin req = '1; tick(); end
        rst_n = 1'b1;
        req = '0; tick();

        // R2: fixed priority under full read load starves client 3
        clear_counts();
        wr = '0; lo = '1; hi = '1;
        for (int i = 0; i < 12; i++) begin req = '1; tick(); end
        chk(gcount[0] == 12 && gcount[3] == 0, "R2 starvation", DW'(gcount[3]), 0);

        // R4: mode change while requests pending is not taken
        policy_sel = 1'b1;
        for (int i = 0; i < 3; i++) begin
            req = '1; tick();
            chk(seen_ack == 4'b0001, "R4 policy held", DW'(seen_ack), 1);
        end
        req = '0; tick();
        // R3: round-robin fairness under full load
        clear_counts();
        for (int i = 0; i < 40; i++) begin req = '1; tick(); end
        for (int c = 0; c < N; c++)
            chk(gcount[c] == 10, "R3 fair share", DW'(gcount[c]), 10);

        // R3: pointer holds across idle cycles
        req = 4'b0010; tick();
        req = '0; tick(); tick(); tick();
        req = 4'b1011; tick();
        chk(seen_ack == 4'b1000, "R3 pointer held", DW'(seen_ack), 8);

        // random traffic in round-robin mode
        for (int i = 0; i < 400; i++) begin rand_inputs(60); tick(); end

        // back to fixed priority, then random traffic
        req = '0; policy_sel = 1'b0; tick();
        for (int i = 0; i < 400; i++) begin rand_inputs(50); tick(); end

        // R7/R8: directed write then low-only read of same address
        req = '0; tick();
        req = 4'b0100; wr = 4'b0100; lo = '1; hi = '1;
        addr[2*AW +: AW] = 8'd5; wdata[2*DW +: DW] = 64'hA5A5_0001_5A5A_0002;
        tick();
        req = 4'b0010; wr = '0; lo = 4'b0010; hi = '0; addr[1*AW +: AW] = 8'd5;
        tick();
        req = '0;
        for (int i = 0; i < LAT + 1; i++) tick();

        // R9: reset with reads in flight clears the pipeline
        wr = '0;
        req = 4'b0001; tick();
        req = 4'b0010; tick();
        req = '0; rst_n = 1'b0; tick();
        rst_n = 1'b1;
        for (int i = 0; i < LAT + 2; i++) tick();
        finish_run();
    end
endmodule